// File: doc/BRIEF.md
# Modem Task Status and Interrupt Register

This block holds the status byte that a host microcontroller reads from a packet data modem. It tracks four flags: data buffer free, interleave buffer empty, de-interleave overflow, and check (CRC/FEC) error. It also tracks a summary interrupt request. Two groups of inputs drive the flags. The host side supplies command-register task writes, status reads, and the power-save and transmit/receive mode bits. The datapath supplies pulses for transmit buffer ready, receive task done, late receive task and check results, plus the current fill level of the interleave buffer.

A change in either mode bit, or a RESET task, returns the flags to their idle values without raising the interrupt. Ordinary tasks clear the buffer-free and interleave-empty flags. Datapath events set individual flags, and some of those events raise the interrupt. A status read clears the interrupt request and the overflow flag. In transmit mode, an idle output tells the transmit path to drive its mid-level bias value whenever the interleave buffer has run empty.

Top module: `modem_status_irq`

## Requirements
- R1: After reset the mode is taken as receive with power-save off. The status byte reads 0x40: only the buffer-free flag is set, and `tx_idle` is 0.
- R2: A task write whose code is not 0 (NULL), 1 (RESET) or 2 (TSO) clears the buffer-free and interleave-empty flags at the next edge. This clear wins over a set event in the same cycle. Codes 0 and 2 leave every flag unchanged.
- R3: In transmit mode, a `tx_ready` pulse sets the buffer-free flag and raises the interrupt.
- R4: In receive mode, an `rx_done` pulse sets the buffer-free flag and raises the interrupt.
- R5: A RESET task (code 1), or a change of `psave` or `tx_mode`, sets buffer-free and interleave-empty. It also clears overflow and check-error. It never raises the interrupt, leaves the interrupt otherwise unchanged, and takes priority over all datapath events in that cycle.
- R6: In transmit mode, an interleave level below 2 while the interleave-empty flag is 0 sets that flag and raises the interrupt. In receive mode the flag reads 0 and the level is ignored.
- R7: In receive mode, a `late_task` pulse sets the overflow flag and raises the interrupt. A status read clears the flag, but a set in the same cycle wins. In transmit mode the flag reads 0 and `late_task` is ignored.
- R8: In receive mode, a `chk_valid` pulse loads `chk_err` into the check-error flag without raising the interrupt. In transmit mode the flag reads 0 and check results are ignored.
- R9: A status read clears the interrupt bit, unless an interrupt-raising event occurs in the same cycle, in which case the bit stays 1.
- R10: `tx_idle` is 1 exactly when the mode is transmit and the interleave-empty flag is set.
- R11: The status byte layout is: bit 7 interrupt, bit 6 buffer-free, bit 5 interleave-empty, bit 4 overflow, bit 3 check-error, and bits 2..0 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | Mode bit: 1 transmit, 0 receive |
| psave | input | 1 | Power-save mode bit |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_task | input | TASK_W | Task code being written |
| stat_rd | input | 1 | Status register read strobe |
| tx_ready | input | 1 | Transmit path can take new buffer data and a new task |
| rx_done | input | 1 | Receive task finished, data placed in buffer |
| ib_level | input | IB_W | Bits remaining in the interleave buffer |
| late_task | input | 1 | Receive task arrived too late for continuous reception |
| chk_valid | input | 1 | CRC or FEC result available |
| chk_err | input | 1 | Result shows errors |
| status | output | 8 | Status byte |
| tx_idle | output | 1 | Drive mid-level idle value on transmit output |

## Verification
The assertions assume that every strobe and datapath pulse is synchronous and lasts a single cycle. They also assume that the mode inputs are stable between edges, so that a mode change is seen as one differing sample. The stimulus drives all inputs only at the falling edge. It raises every pulse for exactly one cycle and holds the mode bits until a vector changes them on purpose. Collisions are produced on purpose, with a read against an event and a task write against a set, and only in the combinations the priority rules define.

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int TASK_W = 4,
  parameter int IB_W = 8,
  parameter logic [TASK_W-1:0] T_NULL = 0,
  parameter logic [TASK_W-1:0] T_RESET = 1,
  parameter logic [TASK_W-1:0] T_TSO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_mode,
  input  logic              psave,
  input  logic              cmd_wr,
  input  logic [TASK_W-1:0] cmd_task,
  input  logic              stat_rd,
  input  logic              tx_ready,
  input  logic              rx_done,
  input  logic [IB_W-1:0]   ib_level,
  input  logic              late_task,
  input  logic              chk_valid,
  input  logic              chk_err,
  output logic [7:0]        status,
  output logic              tx_idle
);

  logic mode_tx_q, psave_q;
  logic bfree_q, ibempty_q, ovf_q, crc_q, irq_q;

  wire mode_chg  = (tx_mode != mode_tx_q) || (psave != psave_q);
  wire reset_tsk = cmd_wr && (cmd_task == T_RESET);
  wire silent    = mode_chg || reset_tsk;
  wire task_clr  = cmd_wr && (cmd_task != T_NULL) && (cmd_task != T_RESET) && (cmd_task != T_TSO);
  wire ib_low    = ib_level < IB_W'(2);

  wire bfree_set = !silent && !task_clr && (mode_tx_q ? tx_ready : rx_done);
  wire ibe_set   = !silent && !task_clr && mode_tx_q && ib_low && !ibempty_q;
  wire ovf_set   = !silent && !mode_tx_q && late_task;
  wire crc_load  = !silent && !mode_tx_q && chk_valid;
  wire irq_set   = bfree_set || ibe_set || ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_tx_q <= 1'b0;
      psave_q   <= 1'b0;
      bfree_q   <= 1'b1;
      ibempty_q <= 1'b1;
      ovf_q     <= 1'b0;
      crc_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      mode_tx_q <= tx_mode;
      psave_q   <= psave;

      if (silent)         bfree_q <= 1'b1;
      else if (task_clr)  bfree_q <= 1'b0;
      else if (bfree_set) bfree_q <= 1'b1;

      if (silent)         ibempty_q <= 1'b1;
      else if (task_clr)  ibempty_q <= 1'b0;
      else if (ibe_set)   ibempty_q <= 1'b1;

      if (silent)         ovf_q <= 1'b0;
      else if (ovf_set)   ovf_q <= 1'b1;
      else if (stat_rd)   ovf_q <= 1'b0;

      if (silent)         crc_q <= 1'b0;
      else if (crc_load)  crc_q <= chk_err;

      if (irq_set)        irq_q <= 1'b1;
      else if (stat_rd)   irq_q <= 1'b0;
    end
  end

  assign status  = {irq_q, bfree_q, ibempty_q & mode_tx_q, ovf_q & ~mode_tx_q,
                    crc_q & ~mode_tx_q, 3'b000};
  assign tx_idle = mode_tx_q & ibempty_q;

  AST_TASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_task > T_TSO && !mode_chg) |=> (!bfree_q && !ibempty_q)); // R2
  AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg || reset_tsk) |=> (bfree_q && ibempty_q && !ovf_q && !crc_q)); // R5
  AST_SILENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_chg || reset_tsk) && !irq_q) |=> !irq_q); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !stat_rd) |=> irq_q); // R9
  AST_TX_BFREE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tx_q && tx_mode == mode_tx_q && psave == psave_q && tx_ready && !cmd_wr)
      |=> (bfree_q && irq_q)); // R3
  AST_RX_BFREE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_tx_q && tx_mode == mode_tx_q && psave == psave_q && rx_done && !cmd_wr)
      |=> (bfree_q && irq_q)); // R4
  AST_OVF_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> !mode_tx_q); // R7
  AST_CRC_RX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_q |-> !mode_tx_q); // R8

endmodule

// File: tb/sim_modem_status_irq.sv
module sim_modem_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_mode = 1'b0, psave = 1'b0, cmd_wr = 1'b0, stat_rd = 1'b0;
  logic [3:0] cmd_task = '0;
  logic tx_ready = 1'b0, rx_done = 1'b0, late_task = 1'b0, chk_valid = 1'b0, chk_err = 1'b0;
  logic [7:0] ib_level = 8'd9;
  logic [7:0] status;
  logic tx_idle;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  modem_status_irq u0 (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .psave(psave), .cmd_wr(cmd_wr),
    .cmd_task(cmd_task), .stat_rd(stat_rd), .tx_ready(tx_ready), .rx_done(rx_done),
    .ib_level(ib_level), .late_task(late_task), .chk_valid(chk_valid), .chk_err(chk_err),
    .status(status), .tx_idle(tx_idle)
  );

  // {psave,tx}, wr, task, rd, {txr,rxd,iblow,late,cv,ce}, exp status, exp idle
  localparam int NV = 25;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 1'b1, 4'd5, 1'b0, 6'b000000, 8'h00, 1'b0}, // R2 ordinary task clears
    {2'b00, 1'b0, 4'd0, 1'b0, 6'b010000, 8'hC0, 1'b0}, // R4 rx done
    {2'b00, 1'b0, 4'd0, 1'b1, 6'b000000, 8'h40, 1'b0}, // R9 read clears irq
    {2'b00, 1'b0, 4'd0, 1'b0, 6'b000100, 8'hD0, 1'b0}, // R7 late task
    {2'b00, 1'b0, 4'd0, 1'b1, 6'b000000, 8'h40, 1'b0}, // R7 read clears overflow
    {2'b00, 1'b0, 4'd0, 1'b0, 6'b000011, 8'h48, 1'b0}, // R8 error loaded
    {2'b00, 1'b0, 4'd0, 1'b0, 6'b000010, 8'h40, 1'b0}, // R8 clean result
    {2'b00, 1'b0, 4'd0, 1'b0, 6'b000011, 8'h48, 1'b0}, // R8 error again
    {2'b01, 1'b0, 4'd0, 1'b0, 6'b000000, 8'h60, 1'b1}, // R5 R10 mode change to tx
    {2'b01, 1'b1, 4'd0, 1'b0, 6'b000000, 8'h60, 1'b1}, // R2 NULL no effect
    {2'b01, 1'b1, 4'd2, 1'b0, 6'b000000, 8'h60, 1'b1}, // R2 TSO no effect
    {2'b01, 1'b1, 4'd3, 1'b0, 6'b000000, 8'h00, 1'b0}, // R2 R10 task 3 clears
    {2'b01, 1'b0, 4'd0, 1'b0, 6'b100000, 8'hC0, 1'b0}, // R3 tx ready
    {2'b01, 1'b0, 4'd0, 1'b0, 6'b001000, 8'hE0, 1'b1}, // R6 interleave low
    {2'b01, 1'b0, 4'd0, 1'b1, 6'b000000, 8'h60, 1'b1}, // R9 read
    {2'b01, 1'b0, 4'd0, 1'b0, 6'b000111, 8'h60, 1'b1}, // R7 R8 ignored in tx
    {2'b01, 1'b1, 4'd7, 1'b0, 6'b100000, 8'h00, 1'b0}, // R2 write beats tx ready
    {2'b01, 1'b0, 4'd0, 1'b1, 6'b001000, 8'hA0, 1'b1}, // R9 R6 event beats read
    {2'b01, 1'b1, 4'd1, 1'b0, 6'b000000, 8'hE0, 1'b1}, // R5 RESET keeps irq
    {2'b01, 1'b0, 4'd0, 1'b1, 6'b000000, 8'h60, 1'b1}, // R9 read
    {2'b01, 1'b1, 4'd1, 1'b0, 6'b000000, 8'h60, 1'b1}, // R5 RESET raises nothing
    {2'b11, 1'b0, 4'd0, 1'b0, 6'b000000, 8'h60, 1'b1}, // R5 power-save change
    {2'b10, 1'b0, 4'd0, 1'b0, 6'b000000, 8'h40, 1'b0}, // R5 R11 back to rx
    {2'b10, 1'b0, 4'd0, 1'b1, 6'b010000, 8'hC0, 1'b0}, // R9 R4 event beats read
    {2'b10, 1'b0, 4'd0, 1'b1, 6'b001000, 8'h40, 1'b0}  // R6 level ignored in rx
  };

  task automatic check(input string req, input logic [7:0] es, input logic ei);
    checks++;
    if (status !== es || tx_idle !== ei) begin
      fails++;
      $display("FAIL %s: status=%h idle=%b expected status=%h idle=%b", req, status, tx_idle, es, ei);
    end
  endtask

  task automatic drive(input logic [22:0] v);
    {psave, tx_mode} = v[22:21];
    cmd_wr = v[20]; cmd_task = v[19:16]; stat_rd = v[15];
    {tx_ready, rx_done} = v[14:13];
    ib_level = v[12] ? 8'd1 : 8'd9;
    {late_task, chk_valid, chk_err} = v[11:9];
  endtask

  task automatic step(input logic [22:0] v, input string req);
    drive(v);
    @(negedge clk);
    check(req, v[8:1], v[0]);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", 8'h40, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 R11 after release", 8'h40, 1'b0);
    for (int i = 0; i < NV; i++) step(VEC[i], $sformatf("vector %0d", i));
    step({2'b10, 1'b0, 4'd0, 1'b0, 6'b000100, 8'hD0, 1'b0}, "R7 late in rx");
    step({2'b10, 1'b0, 4'd0, 1'b0, 6'b000011, 8'hD8, 1'b0}, "R8 R11 error bit 3");
    step({2'b10, 1'b1, 4'd1, 1'b0, 6'b000000, 8'hC0, 1'b0}, "R5 RESET clears ovf and crc");
    step({2'b10, 1'b0, 4'd0, 1'b1, 6'b000100, 8'hD0, 1'b0}, "R7 set beats read");
    step({2'b10, 1'b0, 4'd0, 1'b0, 6'b000000, 8'hD0, 1'b0}, "R7 flag holds");
    drive('0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 8'h40, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 8'h40, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule